// File: doc/BRIEF.md
# Phrase Pager Seven-Segment Driver

This block drives a four-digit, time-multiplexed seven-segment display so that it can show a phrase longer than four characters. The phrase is held as two four-character words. The block shows them one after the other as pages, and by default the pages are "SOLD" and " OUT". A display register holds the page that is currently shown. A decoder turns each stored character code (8-bit ASCII) into a segment pattern for the digit that is being lit.

Every flip-flop runs on the single system clock. Two internal counters produce one-cycle enable pulses. The scan enable steps through the digits at roughly 1 kHz per digit. The page enable swaps the page after a dwell time, which is 1 second by default and can be set by a parameter. The `pause` input freezes the page timer so that the current page stays up, while the digit scan keeps running. The segment and digit outputs are active-low, which suits a common-anode display.

Top module: `phrase_pager_7seg`

## Requirements
- R1: After reset the first word (`WORD_A`, default "SOLD") is shown. After one dwell period the second word (`WORD_B`, default " OUT", right-aligned with a leading space) is shown. The two words then alternate.
- R2: The page changes at the end of each `DWELL_CYC = CLK_HZ/1000*DWELL_MS` clock cycles of unpaused running. A page therefore stays up for exactly `DWELL_CYC` cycles.
- R3: The lit digit advances once every `SCAN_DIV = CLK_HZ/(4*REFRESH_HZ)` cycles, in the order 0,1,2,3,0. Digit k shows character k of the page counted from the left, and digit 0 carries the most significant byte of the word.
- R4: In every cycle exactly one bit of `dig_n` is low. Bit k is low while digit k is lit.
- R5: `seg_n[6:0]` is {g,f,e,d,c,b,a}, active-low. The active-high patterns are: S=7'h6D, O=7'h3F, L=7'h38, D=7'h5E, U=7'h3E, T=7'h78.
- R6: The space code (8'h20) and every code other than uppercase S, O, L, D, U, T and space give all segments off (`seg_n` = 7'h7F).
- R7: The display register changes only on a page-swap enable. On that enable it reloads from whichever stored word is not currently shown.
- R8: Reset selects the first page, restarts the dwell timer and the scan timer, and lights digit 0.
- R9: While `pause` is high the dwell timer holds its count and the page does not change. The digit scan continues at its normal rate. When `pause` is released, timing resumes from the held count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pause | input | 1 | Holds the page timer while high |
| seg_n | output | 7 | Segment lines {g,f,e,d,c,b,a}, active-low |
| dig_n | output | 4 | Digit enables, active-low, bit k = digit k |

## Verification
The bench builds the block with `CLK_HZ=1000`, `REFRESH_HZ=50` and `DWELL_MS=40`, so a digit stays lit for 5 cycles and a page for 40 cycles. With these values several full page alternations, including a pause that spans a page boundary, fit into a few hundred cycles, and every scan step and page swap can be checked in the exact cycle it occurs. A second instance is built with the words "UT D" and "?z*1". It covers the U, T and D patterns and shows that lowercase and punctuation codes blank the digit.

// File: rtl/pager_pkg.sv
package pager_pkg;

    localparam int DIGITS = 4;
    localparam int CHAR_W = 8;
    localparam int SEG_W  = 7;
    localparam int IDX_W  = $clog2(DIGITS);

    typedef logic [CHAR_W-1:0] char_t;
    typedef logic [SEG_W-1:0]  seg_t;      // {g,f,e,d,c,b,a}, active-high
    typedef logic [IDX_W-1:0]  digit_idx_t;

    typedef enum logic {
        PAGE_FIRST  = 1'b0,
        PAGE_SECOND = 1'b1
    } page_e;

    typedef struct packed {
        page_e                   page;
        char_t [DIGITS-1:0]      chars;   // chars[DIGITS-1] is the leftmost
    } page_state_t;

    // Character code to lit segments; anything not listed stays dark.
    function automatic seg_t char_to_seg(char_t c);
        case (c)
            8'h53:   return 7'h6D;  // S
            8'h4F:   return 7'h3F;  // O
            8'h4C:   return 7'h38;  // L
            8'h44:   return 7'h5E;  // D
            8'h55:   return 7'h3E;  // U
            8'h54:   return 7'h78;  // T
            default: return 7'h00;  // space and unsupported codes
        endcase
    endfunction

    // Digit k (0 = leftmost) reads the matching byte of the page.
    function automatic char_t char_at(char_t [DIGITS-1:0] chars, digit_idx_t k);
        return chars[digit_idx_t'(DIGITS-1) - k];
    endfunction

endpackage

// File: rtl/pager_tick_gen.sv
module pager_tick_gen #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == CW'(DIV - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (run) begin
            cnt <= tick ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pager_page_store.sv
module pager_page_store
    import pager_pkg::*;
#(
    parameter logic [DIGITS*CHAR_W-1:0] WORD_A = "SOLD",
    parameter logic [DIGITS*CHAR_W-1:0] WORD_B = " OUT"
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        swap,
    output page_state_t pstate
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pstate.page  <= PAGE_FIRST;
            pstate.chars <= WORD_A;
        end else if (swap) begin
            if (pstate.page == PAGE_FIRST) begin
                pstate.page  <= PAGE_SECOND;
                pstate.chars <= WORD_B;
            end else begin
                pstate.page  <= PAGE_FIRST;
                pstate.chars <= WORD_A;
            end
        end
    end
endmodule

// File: rtl/pager_digit_scan.sv
module pager_digit_scan
    import pager_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    output digit_idx_t        idx,
    output logic [DIGITS-1:0] dig_n
);
    always_ff @(posedge clk) begin
        if (rst) begin
            idx <= '0;
        end else if (step) begin
            idx <= idx + 1'b1;
        end
    end

    always_comb begin
        dig_n      = '1;
        dig_n[idx] = 1'b0;
    end
endmodule

// File: rtl/phrase_pager_7seg.sv
module phrase_pager_7seg
    import pager_pkg::*;
#(
    parameter int                       CLK_HZ     = 100_000_000,
    parameter int                       REFRESH_HZ = 1000,
    parameter int                       DWELL_MS   = 1000,
    parameter logic [DIGITS*CHAR_W-1:0] WORD_A     = "SOLD",
    parameter logic [DIGITS*CHAR_W-1:0] WORD_B     = " OUT"
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pause,
    output logic [SEG_W-1:0]  seg_n,
    output logic [DIGITS-1:0] dig_n
);
    localparam int SCAN_RAW  = CLK_HZ / (DIGITS * REFRESH_HZ);
    localparam int SCAN_DIV  = (SCAN_RAW > 0) ? SCAN_RAW : 1;
    localparam int DWELL_RAW = (CLK_HZ / 1000) * DWELL_MS;
    localparam int DWELL_CYC = (DWELL_RAW > 0) ? DWELL_RAW : 1;

    logic        scan_tick;
    logic        dwell_tick;
    digit_idx_t  scan_idx;
    page_state_t pstate;

    pager_tick_gen #(.DIV(SCAN_DIV)) u_scan_tick (
        .clk  (clk),
        .rst  (rst),
        .run  (1'b1),
        .tick (scan_tick)
    );

    pager_tick_gen #(.DIV(DWELL_CYC)) u_dwell_tick (
        .clk  (clk),
        .rst  (rst),
        .run  (!pause),
        .tick (dwell_tick)
    );

    pager_page_store #(.WORD_A(WORD_A), .WORD_B(WORD_B)) u_store (
        .clk    (clk),
        .rst    (rst),
        .swap   (dwell_tick),
        .pstate (pstate)
    );

    pager_digit_scan u_scan (
        .clk   (clk),
        .rst   (rst),
        .step  (scan_tick),
        .idx   (scan_idx),
        .dig_n (dig_n)
    );

    assign seg_n = ~char_to_seg(char_at(pstate.chars, scan_idx));
endmodule

// File: rtl/phrase_pager_7seg_chk.sv
module phrase_pager_7seg_chk
    import pager_pkg::*;
#(
    parameter logic [DIGITS*CHAR_W-1:0] WORD_A = "SOLD"
) (
    input logic              clk,
    input logic              rst,
    input logic              pause,
    input logic              scan_tick,
    input logic              dwell_tick,
    input digit_idx_t        idx,
    input page_state_t       pstate,
    input logic [DIGITS-1:0] dig_n
);
    // R4: a single digit is driven at any time
    a_r4_one_digit: assert property (@(posedge clk) disable iff (rst)
        $countones(~dig_n) == 1);

    // R3: the scan pointer steps by one on its enable and holds otherwise
    a_r3_scan_step: assert property (@(posedge clk) disable iff (rst)
        scan_tick |=> idx == digit_idx_t'($past(idx) + 1'b1));

    a_r3_scan_hold: assert property (@(posedge clk) disable iff (rst)
        !scan_tick |=> $stable(idx));

    // R7: display register only moves on a page-swap enable, and then flips page
    a_r7_reload_gated: assert property (@(posedge clk) disable iff (rst)
        !dwell_tick |=> $stable(pstate));

    a_r7_reload_flips: assert property (@(posedge clk) disable iff (rst)
        dwell_tick |=> pstate.page != $past(pstate.page));

    // R9: pause freezes the shown page
    a_r9_pause_freezes: assert property (@(posedge clk) disable iff (rst)
        pause |=> $stable(pstate));

    // R8: reset state
    a_r8_reset_values: assert property (@(posedge clk)
        rst |=> (idx == '0 && pstate.page == PAGE_FIRST && pstate.chars == WORD_A));
endmodule

bind phrase_pager_7seg phrase_pager_7seg_chk #(.WORD_A(WORD_A)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .pause      (pause),
    .scan_tick  (scan_tick),
    .dwell_tick (dwell_tick),
    .idx        (scan_idx),
    .pstate     (pstate),
    .dig_n      (dig_n)
);

// File: tb/phrase_pager_7seg_tb.sv
module phrase_pager_7seg_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CLK_HZ     = 1000;
    localparam int REFRESH_HZ = 50;
    localparam int DWELL_MS   = 40;
    localparam int SD         = CLK_HZ / (4 * REFRESH_HZ);   // 5
    localparam int DW         = CLK_HZ / 1000 * DWELL_MS;    // 40
    localparam logic [31:0] WA  = "SOLD";
    localparam logic [31:0] WB  = " OUT";
    localparam logic [31:0] WA2 = "UT D";
    localparam logic [31:0] WB2 = "?z*1";

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pause = 1'b0;
    logic [6:0] seg_n, seg_n2;
    logic [3:0] dig_n, dig_n2;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    phrase_pager_7seg #(.CLK_HZ(CLK_HZ), .REFRESH_HZ(REFRESH_HZ), .DWELL_MS(DWELL_MS),
                        .WORD_A(WA), .WORD_B(WB)) u_dut (
        .clk(clk), .rst(rst), .pause(pause), .seg_n(seg_n), .dig_n(dig_n));

    phrase_pager_7seg #(.CLK_HZ(CLK_HZ), .REFRESH_HZ(REFRESH_HZ), .DWELL_MS(DWELL_MS),
                        .WORD_A(WA2), .WORD_B(WB2)) u_alt (
        .clk(clk), .rst(rst), .pause(1'b0), .seg_n(seg_n2), .dig_n(dig_n2));

    // Reference timing from R2, R3, R8, R9
    int m_dw, m_dw2, m_sc, m_ix;
    bit m_pg, m_pg2;

    always @(posedge clk) begin
        if (rst) begin
            m_dw <= 0; m_dw2 <= 0; m_sc <= 0; m_ix <= 0; m_pg <= 0; m_pg2 <= 0;
        end else begin
            if (!pause) begin
                if (m_dw == DW - 1) begin m_dw <= 0; m_pg <= ~m_pg; end
                else m_dw <= m_dw + 1;
            end
            if (m_dw2 == DW - 1) begin m_dw2 <= 0; m_pg2 <= ~m_pg2; end
            else m_dw2 <= m_dw2 + 1;
            if (m_sc == SD - 1) begin m_sc <= 0; m_ix <= (m_ix + 1) % 4; end
            else m_sc <= m_sc + 1;
        end
    end

    // Segment patterns from R5 / R6, returned active-low
    function automatic logic [6:0] exp_seg(logic [7:0] c);
        case (c)
            "S": return ~7'h6D;
            "O": return ~7'h3F;
            "L": return ~7'h38;
            "D": return ~7'h5E;
            "U": return ~7'h3E;
            "T": return ~7'h78;
            default: return 7'h7F;
        endcase
    endfunction

    function automatic logic [7:0] char_of(logic [31:0] w, int k);
        return w[(3 - k) * 8 +: 8];
    endfunction

    task automatic chk(bit ok, string req, logic [10:0] act, logic [10:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cmp_main(string req);
        logic [3:0] ed = ~(4'b0001 << m_ix);
        logic [6:0] es = exp_seg(char_of(m_pg ? WB : WA, m_ix));
        chk({dig_n, seg_n} === {ed, es}, req, {dig_n, seg_n}, {ed, es});
    endtask

    task automatic cmp_alt(string req);
        logic [3:0] ed = ~(4'b0001 << m_ix);
        logic [6:0] es = exp_seg(char_of(m_pg2 ? WB2 : WA2, m_ix));
        chk({dig_n2, seg_n2} === {ed, es}, req, {dig_n2, seg_n2}, {ed, es});
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1; pause = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // R8, R1: state directly after reset
    task automatic t_reset();
        do_reset();
        chk(dig_n === 4'b1110, "R8 digit0 after reset", {7'b0, dig_n}, 11'h00E);
        chk(seg_n === ~7'h6D, "R1 first char S", {4'b0, seg_n}, {4'b0, ~7'h6D});
    endtask

    // R3, R4, R5: scan order and per-digit characters on page one
    task automatic t_scan();
        int seen = 0;
        for (int i = 0; i < 4 * SD; i++) begin
            @(negedge clk);
            cmp_main("R3 scan order");
            if (seg_n === ~7'h38) seen++;
        end
        chk(seen == SD, "R5 L lit for one digit slot", 11'(seen), 11'(SD));
    endtask

    // R1, R2, R6, R7: page swaps on exact cycles and wraps back
    task automatic t_pages();
        bit saw_blank = 0;
        for (int i = 0; i < 3 * DW; i++) begin
            @(negedge clk);
            cmp_main("R2 page timing");
            if (m_pg && m_ix == 0 && seg_n === 7'h7F) saw_blank = 1;
        end
        chk(saw_blank, "R6 space blanks digit0 on page two", 11'(saw_blank), 11'd1);
    endtask

    // R9: pause across a page boundary; scan keeps moving
    task automatic t_pause();
        logic [3:0] d0;
        int moves = 0;
        @(negedge clk); pause = 1'b1;
        d0 = dig_n;
        for (int i = 0; i < DW + 7; i++) begin
            @(negedge clk);
            cmp_main("R9 paused");
            if (dig_n !== d0) begin moves++; d0 = dig_n; end
        end
        chk(moves >= (DW + 7) / SD - 1, "R9 scan continues", 11'(moves), 11'((DW + 7) / SD - 1));
        pause = 1'b0;
        for (int i = 0; i < 2 * DW; i++) begin
            @(negedge clk);
            cmp_main("R9 resume");
        end
    endtask

    // R5, R6 on the alternate words
    task automatic t_alt();
        do_reset();
        for (int i = 0; i < 2 * DW; i++) begin
            @(negedge clk);
            cmp_alt("R5 R6 alt words");
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        t_scan();
        t_pages();
        t_pause();
        t_alt();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule